// File: doc/BRIEF.md
# Sliding-Window Binary Convolution Array

This block is the arithmetic core of a binary convolution engine with a fixed kernel. Activations and weights are single bits, where bit value 1 stands for +1 and bit value 0 stands for −1. Each kernel row has its own row unit. A row unit holds the weights for that kernel row and a short shift register of activation columns, each column being `CH` channels wide. Every channel bit goes through an XNOR against its weight. The matches are counted per column and summed per row, and an adder over all row units forms a signed partial sum at full width. That partial sum is left unbinarized so that a later stage can add residual paths to it.

A scheduler drives the block with four commands. `LOAD_ROW` pushes one column into every row unit, and `KS` of these beats fill a fresh window at the start of an image row. `SHIFT_COL` slides the window one step to the right by bringing in a single new column. `ROTATE` moves the window one row down: every row unit takes the activations of the unit below it, the bottom unit takes a whole new row, and all weights stay where they are. `LOAD_W` writes one kernel row of weights.

Channel counts larger than `CH` are handled by chaining. With chaining, a result is added to the previous partial sum instead of replacing it.

Top module: `bconv_array`

## Requirements
- R1: After reset, `psum_o` is 0, `psum_valid_o` is 0, `ignored_o` is 0, and the activation window is empty, so it is not full.
- R2: A result equals 2·M − KR·KS·CH, where M counts the positions (row r, column j, channel b) at which the activation bit equals the weight bit.
- R3: Command codes are 0 `LOAD_W`, 1 `LOAD_ROW`, 2 `SHIFT_COL` and 3 `ROTATE`, and a command is taken only when `cmd_valid` is 1. Each `LOAD_ROW` shifts `col_in[r*CH +: CH]` into row unit r as its newest column. The beat that brings the fill count to KS produces a result.
- R4: While the window is full, `SHIFT_COL` drops the oldest column of every row unit and inserts `col_in[r*CH +: CH]` as the newest. It then produces a result.
- R5: While the window is full, `ROTATE` gives row unit r the columns of row unit r+1. The last row unit takes `row_in`, with column j (j = 0 oldest) at bits `[j*CH +: CH]`. It then produces a result.
- R6: `LOAD_W` writes `row_in` as the weights of row unit `w_sel`, with weight column j paired to activation column j. It is accepted at any time, leaves the window and its fill state unchanged, and produces no result.
- R7: A `SHIFT_COL` or `ROTATE` that arrives while the window is not full changes nothing and produces no result. `ignored_o` is then 1 for the single cycle after the clock edge that sampled it.
- R8: A `LOAD_ROW` on a full window starts a new fill at count 1. The window stays not full until KS `LOAD_ROW` beats have been taken.
- R9: If `cmd_chain` is 1 on a command that produces a result, the result is added to the previous `psum_o`, modulo 2^PSUM_W. Otherwise the result replaces `psum_o`.
- R10: A result appears on `psum_o`, together with a one-cycle `psum_valid_o`, after the second clock edge from the edge that sampled its command. `psum_o` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code |
| cmd_chain | input | 1 | Add the result to the previous partial sum |
| w_sel | input | SEL_W | Row unit targeted by `LOAD_W` |
| col_in | input | KR*CH | One new column per row unit |
| row_in | input | KS*CH | New bottom row for `ROTATE`, or weight row for `LOAD_W` |
| psum_o | output | PSUM_W | Signed partial sum |
| psum_valid_o | output | 1 | New partial sum this cycle |
| ignored_o | output | 1 | The previous command was dropped because the window was not full |

## Verification
The bound checker watches the causality rules on every cycle:
- a result only ever follows an accepted window command by exactly two edges;
- a weight load or a dropped command never yields a result;
- `ignored_o` only follows a column or row command;
- `psum_o` is frozen whenever no result is signalled.

Only the bench's scenarios can show the arithmetic itself. These cover the all-match and all-mismatch extremes, the column order inside the shift register, rotation between row units, fill restarts, and chained accumulation with wrap. The bench compares them against an independent model of the window.

// File: rtl/bconv_pkg.sv
package bconv_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_W    = 2'd0,
        OP_LOAD_ROW  = 2'd1,
        OP_SHIFT_COL = 2'd2,
        OP_ROTATE    = 2'd3
    } bconv_op_e;
endpackage

// File: rtl/bconv_ctrl.sv
// Window fill tracking and command acceptance.
module bconv_ctrl
    import bconv_pkg::*;
#(
    parameter int KS = 3,
    localparam int FW = $clog2(KS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_chain,
    output logic       push_en,
    output logic       rot_en,
    output logic       wld_en,
    output logic       fire_o,
    output logic       chain_o,
    output logic       ignored_o
);
    typedef struct packed {
        logic [FW-1:0] fill;
        logic          fire;
        logic          chain;
        logic          ign;
    } ctrl_t;

    ctrl_t     st_q, st_d;
    bconv_op_e op;
    logic      full;

    always_comb begin
        op      = bconv_op_e'(cmd_op);
        full    = (st_q.fill == FW'(KS));
        st_d    = st_q;
        st_d.fire = 1'b0;
        st_d.ign  = 1'b0;
        push_en = 1'b0;
        rot_en  = 1'b0;
        wld_en  = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_LOAD_W: wld_en = 1'b1;
                OP_LOAD_ROW: begin
                    push_en   = 1'b1;
                    st_d.fill = full ? FW'(1) : st_q.fill + FW'(1);
                    st_d.fire = (st_d.fill == FW'(KS));
                end
                OP_SHIFT_COL: begin
                    if (full) begin
                        push_en   = 1'b1;
                        st_d.fire = 1'b1;
                    end else begin
                        st_d.ign = 1'b1;
                    end
                end
                OP_ROTATE: begin
                    if (full) begin
                        rot_en    = 1'b1;
                        st_d.fire = 1'b1;
                    end else begin
                        st_d.ign = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        st_d.chain = cmd_chain & st_d.fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o    = st_q.fire;
    assign chain_o   = st_q.chain;
    assign ignored_o = st_q.ign;
endmodule

// File: rtl/bconv_row_unit.sv
// One kernel row: weight columns, activation shift register, XNOR-popcount.
module bconv_row_unit #(
    parameter int KS = 3,
    parameter int CH = 8,
    localparam int ROW_BITS = KS * CH,
    localparam int CW       = $clog2(CH + 1),
    localparam int RCW      = $clog2(ROW_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_en,
    input  logic [CH-1:0]       push_col,
    input  logic                row_ld_en,
    input  logic [ROW_BITS-1:0] row_ld,
    input  logic                w_ld_en,
    input  logic [ROW_BITS-1:0] w_ld,
    output logic [ROW_BITS-1:0] acts_o,
    output logic [RCW-1:0]      match_o
);
    typedef struct packed {
        logic [ROW_BITS-1:0] acts;
        logic [ROW_BITS-1:0] wts;
    } ru_t;

    ru_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (row_ld_en) begin
            st_d.acts = row_ld;
        end else if (push_en) begin
            for (int j = 0; j < KS - 1; j++) begin
                st_d.acts[j*CH +: CH] = st_q.acts[(j+1)*CH +: CH];
            end
            st_d.acts[(KS-1)*CH +: CH] = push_col;
        end
        if (w_ld_en) st_d.wts = w_ld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [CW-1:0] col_cnt [KS];

    for (genvar j = 0; j < KS; j++) begin : g_col
        assign col_cnt[j] = CW'($countones(~(st_q.acts[j*CH +: CH] ^ st_q.wts[j*CH +: CH])));
    end

    always_comb begin
        match_o = '0;
        for (int j = 0; j < KS; j++) match_o = match_o + RCW'(col_cnt[j]);
    end

    assign acts_o = st_q.acts;
endmodule

// File: rtl/bconv_array.sv
// Sliding-window binary convolution array top.
module bconv_array
    import bconv_pkg::*;
#(
    parameter int KR     = 3,
    parameter int KS     = 3,
    parameter int CH     = 8,
    parameter int PSUM_W = 16,
    localparam int SEL_W = (KR > 1) ? $clog2(KR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic                     cmd_chain,
    input  logic [SEL_W-1:0]         w_sel,
    input  logic [KR*CH-1:0]         col_in,
    input  logic [KS*CH-1:0]         row_in,
    output logic signed [PSUM_W-1:0] psum_o,
    output logic                     psum_valid_o,
    output logic                     ignored_o
);
    localparam int ROW_BITS = KS * CH;
    localparam int N_BITS   = KR * KS * CH;
    localparam int RCW      = $clog2(ROW_BITS + 1);
    localparam int TCW      = $clog2(N_BITS + 1);

    logic push_en, rot_en, wld_en, fire, chain;

    bconv_ctrl #(.KS(KS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_chain (cmd_chain),
        .push_en   (push_en),
        .rot_en    (rot_en),
        .wld_en    (wld_en),
        .fire_o    (fire),
        .chain_o   (chain),
        .ignored_o (ignored_o)
    );

    logic [ROW_BITS-1:0] acts  [KR];
    logic [RCW-1:0]      match [KR];

    for (genvar r = 0; r < KR; r++) begin : g_row
        logic [ROW_BITS-1:0] rot_src;
        if (r == KR - 1) begin : g_bottom
            assign rot_src = row_in;
        end else begin : g_inner
            assign rot_src = acts[r+1];
        end
        bconv_row_unit #(.KS(KS), .CH(CH)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_en   (push_en),
            .push_col  (col_in[r*CH +: CH]),
            .row_ld_en (rot_en),
            .row_ld    (rot_src),
            .w_ld_en   (wld_en && (w_sel == SEL_W'(r))),
            .w_ld      (row_in),
            .acts_o    (acts[r]),
            .match_o   (match[r])
        );
    end

    logic [TCW-1:0]    total;
    logic [PSUM_W-1:0] wsum;

    always_comb begin
        total = '0;
        for (int r = 0; r < KR; r++) total = total + TCW'(match[r]);
        wsum = (PSUM_W'(total) << 1) - PSUM_W'(N_BITS);
    end

    typedef struct packed {
        logic [PSUM_W-1:0] psum;
        logic              valid;
    } out_t;

    out_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = fire;
        if (fire) st_d.psum = chain ? st_q.psum + wsum : wsum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psum_o       = st_q.psum;
    assign psum_valid_o = st_q.valid;
endmodule

// File: rtl/bconv_array_chk.sv
// Protocol checker bound to the array top.
module bconv_array_chk
    import bconv_pkg::*;
#(
    parameter int PSUM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [PSUM_W-1:0] psum_o,
    input logic              psum_valid_o,
    input logic              ignored_o
);
    logic win_cmd, colrow_cmd, wld_cmd;
    assign win_cmd    = cmd_valid && (cmd_op != OP_LOAD_W);
    assign colrow_cmd = cmd_valid && (cmd_op == OP_SHIFT_COL || cmd_op == OP_ROTATE);
    assign wld_cmd    = cmd_valid && (cmd_op == OP_LOAD_W);

    // R7: a dropped command never yields a result
    a_r7_ignore_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        ignored_o |=> !psum_valid_o);

    // R7: the dropped flag follows a column or row command only
    a_r7_ignore_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ignored_o |-> $past(colrow_cmd));

    // R6: a weight load produces no result
    a_r6_wload_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        wld_cmd |=> ##1 !psum_valid_o);

    // R10: a result always comes from a window command two edges earlier
    a_r10_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        psum_valid_o |-> $past(win_cmd, 2));

    // R10: the partial sum holds between results
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !psum_valid_o |-> $stable(psum_o));
endmodule

bind bconv_array bconv_array_chk #(.PSUM_W(PSUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .psum_o       (psum_o),
    .psum_valid_o (psum_valid_o),
    .ignored_o    (ignored_o)
);

// File: tb/bconv_array_test.sv
module bconv_array_test;
    localparam int KR = 3;
    localparam int KS = 3;
    localparam int CH = 8;
    localparam int PSUM_W = 16;
    localparam int SEL_W = 2;
    localparam int CW = KR * CH;
    localparam int RW = KS * CH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_chain = 1'b0;
    logic [SEL_W-1:0] w_sel = '0;
    logic [CW-1:0] col_in = '0;
    logic [RW-1:0] row_in = '0;
    logic signed [PSUM_W-1:0] psum_o;
    logic psum_valid_o;
    logic ignored_o;

    always #4 clk = ~clk;

    bconv_array #(.KR(KR), .KS(KS), .CH(CH), .PSUM_W(PSUM_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chain(cmd_chain), .w_sel(w_sel), .col_in(col_in), .row_in(row_in),
        .psum_o(psum_o), .psum_valid_o(psum_valid_o), .ignored_o(ignored_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [CH-1:0] m_act [KR][KS];
    logic [CH-1:0] m_wt  [KR][KS];
    int m_fill = 0;
    logic m_fire = 0, m_chain = 0, m_ign = 0, m_valid = 0;
    logic signed [PSUM_W-1:0] m_psum = '0;

    function automatic int win_sum();
        int m = 0;
        for (int r = 0; r < KR; r++)
            for (int j = 0; j < KS; j++)
                for (int b = 0; b < CH; b++)
                    if (m_act[r][j][b] == m_wt[r][j][b]) m++;
        return 2 * m - KR * KS * CH;
    endfunction

    task automatic compare(input string tag);
        n_cmp += 3;
        if (psum_o !== m_psum) begin
            n_bad++;
            $display("FAIL %s psum_o actual=%0d expected=%0d", tag, psum_o, m_psum);
        end
        if (psum_valid_o !== m_valid) begin
            n_bad++;
            $display("FAIL %s psum_valid_o actual=%0b expected=%0b", tag, psum_valid_o, m_valid);
        end
        if (ignored_o !== m_ign) begin
            n_bad++;
            $display("FAIL %s ignored_o actual=%0b expected=%0b", tag, ignored_o, m_ign);
        end
    endtask

    // called at a falling edge; drives one command and checks the next falling edge
    task automatic step(input string tag, input logic v, input logic [1:0] op,
                        input logic ch, input int sel, input logic [CW-1:0] col,
                        input logic [RW-1:0] row);
        int s;
        logic full;
        cmd_valid = v; cmd_op = op; cmd_chain = ch;
        w_sel = SEL_W'(sel); col_in = col; row_in = row;
        s = win_sum();
        m_valid = m_fire;
        if (m_fire) m_psum = m_chain ? PSUM_W'(m_psum + s) : PSUM_W'(s);
        full = (m_fill == KS);
        m_fire = 0; m_ign = 0;
        if (v) begin
            case (op)
                2'd0: for (int j = 0; j < KS; j++) m_wt[sel][j] = row[j*CH +: CH];
                2'd1: begin
                    for (int r = 0; r < KR; r++) begin
                        for (int j = 0; j < KS - 1; j++) m_act[r][j] = m_act[r][j+1];
                        m_act[r][KS-1] = col[r*CH +: CH];
                    end
                    m_fill = full ? 1 : m_fill + 1;
                    m_fire = (m_fill == KS);
                end
                2'd2: if (full) begin
                    for (int r = 0; r < KR; r++) begin
                        for (int j = 0; j < KS - 1; j++) m_act[r][j] = m_act[r][j+1];
                        m_act[r][KS-1] = col[r*CH +: CH];
                    end
                    m_fire = 1;
                end else m_ign = 1;
                default: if (full) begin
                    for (int r = 0; r < KR - 1; r++)
                        for (int j = 0; j < KS; j++) m_act[r][j] = m_act[r+1][j];
                    for (int j = 0; j < KS; j++) m_act[KR-1][j] = row[j*CH +: CH];
                    m_fire = 1;
                end else m_ign = 1;
            endcase
        end
        m_chain = ch;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 2'd2, 1'b0, 0, CW'($urandom()), RW'($urandom()));
    endtask

    function automatic logic [CW-1:0] rcol();
        return CW'({$urandom(), $urandom()});
    endfunction

    function automatic logic [RW-1:0] rrow();
        return RW'({$urandom(), $urandom()});
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < KR; r++)
            for (int j = 0; j < KS; j++) begin m_act[r][j] = '0; m_wt[r][j] = '0; end
        repeat (3) @(negedge clk);
        compare("R1");                       // reset values
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        // empty window after reset: column and row commands dropped
        step("R1", 1, 2'd2, 0, 0, rcol(), rrow());
        step("R7", 1, 2'd3, 0, 0, rcol(), rrow());
        idle("R7", 2);
        // all-ones weights
        for (int r = 0; r < KR; r++) step("R6", 1, 2'd0, 0, r, rcol(), '1);
        idle("R6", 2);
        // fill with all ones: all positions match
        for (int i = 0; i < KS; i++) step("R3", 1, 2'd1, 0, 0, '1, rrow());
        idle("R2", 2);
        // shift in all zeros: all positions mismatch
        for (int i = 0; i < KS; i++) step("R4", 1, 2'd2, 0, 0, '0, rrow());
        idle("R2", 2);
        // random weights, loaded mid-stream
        for (int r = KR - 1; r >= 0; r--) step("R6", 1, 2'd0, 0, r, rcol(), rrow());
        idle("R6", 2);
        // random shifts with idles
        for (int i = 0; i < 20; i++) begin
            step("R4", 1, 2'd2, 0, 0, rcol(), rrow());
            if (i % 4 == 0) idle("R10", 1);
        end
        // rotations
        for (int i = 0; i < 4; i++) step("R5", 1, 2'd3, 0, 0, rcol(), rrow());
        idle("R5", 2);
        // restart fill on full window
        step("R8", 1, 2'd1, 0, 0, rcol(), rrow());
        step("R8", 1, 2'd2, 0, 0, rcol(), rrow());
        step("R8", 1, 2'd3, 0, 0, rcol(), rrow());
        step("R8", 1, 2'd1, 0, 0, rcol(), rrow());
        step("R7", 1, 2'd2, 0, 0, rcol(), rrow());
        step("R8", 1, 2'd1, 0, 0, rcol(), rrow());
        step("R8", 1, 2'd2, 0, 0, rcol(), rrow());
        idle("R8", 2);
        // chained accumulation over channel chunks
        step("R9", 1, 2'd2, 0, 0, rcol(), rrow());
        for (int i = 0; i < 6; i++) step("R9", 1, 2'd2, 1, 0, rcol(), rrow());
        step("R9", 1, 2'd3, 1, 0, rcol(), rrow());
        idle("R10", 5);
        // chaining at the extreme to exercise wrap
        for (int r = 0; r < KR; r++) step("R9", 1, 2'd0, 0, r, rcol(), '1);
        for (int i = 0; i < KS; i++) step("R9", 1, 2'd1, 0, 0, '1, rrow());
        for (int i = 0; i < 500; i++) step("R9", 1, 2'd2, 1, 0, '1, rrow());
        idle("R9", 2);
        // mixed traffic
        for (int i = 0; i < 400; i++)
            step("R2", 1'($urandom() % 4 != 0), 2'($urandom()), 1'($urandom()),
                 int'($urandom() % KR), rcol(), rrow());
        idle("R10", 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule